// File: doc/BRIEF.md
# Exception Return Decode Unit

This block recognises the exception-return instruction of a 32-bit processor that runs two instruction sets, a fixed-width 32-bit set and a mixed 16/32-bit set, and turns it into control requests for the rest of the pipeline. Each cycle that `in_valid` is high, it decodes the presented instruction word under the selected instruction set. It then combines the result with the processor mode, exception level, debug-halt flag, condition result and conditional-block position. One cycle later it presents one registered action.

With the core running, a privileged mode other than User or System produces a branch-and-restore request. The return target comes from the hypervisor link register at exception level 2, and from general register 14 at any other level. With the core halted for debug, the same instruction instead yields a context synchronisation together with a debug status restore.

User and System modes are trapped or flagged as unpredictable. The parameter `UNPRED_AS_UNDEF` decides whether an unpredictable case becomes an undefined-instruction trap or a no-op. Should-be bit mismatches and a bad conditional-block position only raise the unpredictable flag. The status-register datapath and the illegal-return checks belong to other blocks.

Top module: `xret_decode`

## Requirements
- R1: With `iset_mixed`=0, a word matches when bits [27:20] are 0x16 and bits [7:4] are 0x6, and bits [31:28] are not 0xF; any other word gives `match`=0 and no action.
- R2: In the fixed set, a matched word whose bits [19:8] are not zero or whose bits [3:0] are not 0xE still matches and executes, but sets `unpred`.
- R3: With `iset_mixed`=1, a word matches when bits [31:16] are 0xF3DE, bits [15:14] are 10, bit [12] is 0 and bits [7:0] are zero; nominal form 0xF3DE8F00.
- R4: In the mixed set, a matched word with bit [13] set or bits [11:8] other than 0xF still matches and sets `unpred`.
- R5: In the mixed set, `in_cblock`=1 with `last_in_cblock`=0 sets `unpred` on a match; in the fixed set these two inputs have no effect.
- R6: With `cond_pass`=0, a matched instruction reports `match` but asserts none of the actions `do_restore`, `do_dbg_restore`, `ctx_sync`, `undef_trap` or `nop`.
- R7: Not halted, with a mode other than User (10000) and System (11111), the unit asserts `do_restore`. `ret_addr` equals `hyp_link` and `src_hyp`=1 when `el`=2; otherwise `ret_addr` equals `gpr_link` and `src_hyp`=0.
- R8: Not halted, in User or System mode, the unit sets `unpred`. It also asserts `undef_trap` when `UNPRED_AS_UNDEF`=1, and `nop` when it is 0.
- R9: Halted in User mode, the unit asserts `undef_trap` with `unpred`=0 (barring should-be flags).
- R10: Halted in System mode, the unit sets `unpred` and resolves it through `UNPRED_AS_UNDEF` as in R8.
- R11: Halted in any other mode, the unit asserts `ctx_sync` and `do_dbg_restore` together and does not assert `do_restore`.
- R12: Outputs appear exactly one cycle after the `in_valid` edge that captured the inputs. With `in_valid` low, or during reset (`rst` high, synchronous), every output is zero on the next cycle.
- R13: For a matched, executed instruction, exactly one of `do_restore`, `do_dbg_restore`, `undef_trap`, `nop` is high. `ret_addr` and `src_hyp` are zero unless `do_restore` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input strobe |
| instr | input | 32 | Instruction word (mixed set: first halfword in [31:16]) |
| iset_mixed | input | 1 | 0 = fixed 32-bit set, 1 = mixed 16/32-bit set |
| mode | input | 5 | Current processor mode |
| el | input | 2 | Current exception level |
| halted | input | 1 | Core is halted for debug |
| cond_pass | input | 1 | Condition check passed |
| in_cblock | input | 1 | Instruction lies inside a conditional block |
| last_in_cblock | input | 1 | Instruction is the last of its conditional block |
| gpr_link | input | XLEN | Value of general register 14 |
| hyp_link | input | XLEN | Value of the hypervisor link register |
| out_valid | output | 1 | Registered results are valid |
| match | output | 1 | Instruction recognised |
| src_hyp | output | 1 | Return target taken from `hyp_link` |
| ret_addr | output | XLEN | Return target address |
| do_restore | output | 1 | Branch and restore saved status |
| do_dbg_restore | output | 1 | Debug status restore |
| ctx_sync | output | 1 | Context synchronisation |
| undef_trap | output | 1 | Undefined-instruction trap |
| nop | output | 1 | Treat as no-op |
| unpred | output | 1 | Unpredictable condition seen |

## Verification
The bench targets the seam between should-be bits and required bits. A design that rejects a word with a stray bit in [19:8], or with bit [13] set, loses `match` there; one that accepts a wrong [15:14] or a nonzero immediate reports a false match. It presents fixed-set words under the mixed select and the reverse, and a condition field of 0xF, to catch decoders that ignore the set or the condition field. It separates halted User (trap, no unpredictable flag) from halted System (unpredictable) and from halted privileged modes (context sync plus debug restore). It selects the return source at levels 1, 2 and 3, so a design that swaps the link registers or ignores the level shows a wrong `ret_addr`. A second instance built for no-op resolution confirms that the unpredictable cases become `nop` and never trap.

// File: rtl/xret_pkg.sv
package xret_pkg;
  localparam int MODE_W = 5;
  localparam int EL_W   = 2;

  localparam logic [MODE_W-1:0] MODE_USR = 5'b10000;
  localparam logic [MODE_W-1:0] MODE_SYS = 5'b11111;
  localparam logic [MODE_W-1:0] MODE_HYP = 5'b11010;
  localparam logic [EL_W-1:0]   EL_HYP   = 2'd2;

  typedef enum logic [2:0] {
    ACT_NONE    = 3'd0,
    ACT_RESTORE = 3'd1,
    ACT_DBG     = 3'd2,
    ACT_UNDEF   = 3'd3,
    ACT_NOP     = 3'd4
  } xret_act_e;

  typedef struct packed {
    logic match;
    logic sb_bad;
  } xret_dec_t;
endpackage

// File: rtl/xret_fixed_dec.sv
module xret_fixed_dec
  import xret_pkg::*;
#(
  parameter int IW = 32
) (
  input  logic [IW-1:0] instr,
  output xret_dec_t     dec
);
  localparam logic [3:0] COND_NEVER = 4'hF;
  localparam logic [7:0] OPC_HI     = 8'h16;
  localparam logic [3:0] OPC_LO     = 4'h6;
  localparam logic [3:0] SB_LOW     = 4'hE;

  logic cond_ok, opc_ok, sbz_ok, sbo_ok;

  always_comb begin
    cond_ok    = instr[31:28] != COND_NEVER;
    opc_ok     = (instr[27:20] == OPC_HI) && (instr[7:4] == OPC_LO);
    sbz_ok     = instr[19:8] == 12'h000;
    sbo_ok     = instr[3:0] == SB_LOW;
    dec.match  = cond_ok && opc_ok;
    dec.sb_bad = dec.match && !(sbz_ok && sbo_ok);
  end
endmodule

// File: rtl/xret_mixed_dec.sv
module xret_mixed_dec
  import xret_pkg::*;
#(
  parameter int IW = 32
) (
  input  logic [IW-1:0] instr,
  input  logic          in_cblock,
  input  logic          last_in_cblock,
  output xret_dec_t     dec
);
  localparam logic [15:0] HW_FIRST = 16'hF3DE;

  logic fixed_ok, imm_ok, sb_ok, pos_bad;

  always_comb begin
    fixed_ok   = (instr[31:16] == HW_FIRST) && (instr[15:14] == 2'b10) && !instr[12];
    imm_ok     = instr[7:0] == 8'h00;
    sb_ok      = !instr[13] && (instr[11:8] == 4'hF);
    pos_bad    = in_cblock && !last_in_cblock;
    dec.match  = fixed_ok && imm_ok;
    dec.sb_bad = dec.match && (!sb_ok || pos_bad);
  end
endmodule

// File: rtl/xret_resolve.sv
module xret_resolve
  import xret_pkg::*;
#(
  parameter bit UNPRED_AS_UNDEF = 1'b1
) (
  input  logic              match,
  input  logic              cond_pass,
  input  logic              halted,
  input  logic [MODE_W-1:0] mode,
  input  logic [EL_W-1:0]   el,
  output xret_act_e         act,
  output logic              mode_unpred,
  output logic              use_hyp
);
  localparam xret_act_e UNP_ACT = UNPRED_AS_UNDEF ? ACT_UNDEF : ACT_NOP;

  logic is_usr, is_sys, exec;

  always_comb begin
    is_usr      = mode == MODE_USR;
    is_sys      = mode == MODE_SYS;
    exec        = match && cond_pass;
    use_hyp     = el == EL_HYP;
    act         = ACT_NONE;
    mode_unpred = 1'b0;
    if (exec) begin
      if (!halted) begin
        if (is_usr || is_sys) begin
          act         = UNP_ACT;
          mode_unpred = 1'b1;
        end else begin
          act = ACT_RESTORE;
        end
      end else if (is_usr) begin
        act = ACT_UNDEF;
      end else if (is_sys) begin
        act         = UNP_ACT;
        mode_unpred = 1'b1;
      end else begin
        act = ACT_DBG;
      end
    end
  end
endmodule

// File: rtl/xret_decode.sv
module xret_decode
  import xret_pkg::*;
#(
  parameter int XLEN            = 32,
  parameter bit UNPRED_AS_UNDEF = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [31:0]       instr,
  input  logic              iset_mixed,
  input  logic [4:0]        mode,
  input  logic [1:0]        el,
  input  logic              halted,
  input  logic              cond_pass,
  input  logic              in_cblock,
  input  logic              last_in_cblock,
  input  logic [XLEN-1:0]   gpr_link,
  input  logic [XLEN-1:0]   hyp_link,
  output logic              out_valid,
  output logic              match,
  output logic              src_hyp,
  output logic [XLEN-1:0]   ret_addr,
  output logic              do_restore,
  output logic              do_dbg_restore,
  output logic              ctx_sync,
  output logic              undef_trap,
  output logic              nop,
  output logic              unpred
);
  localparam int IW = 32;

  xret_dec_t dec_fix, dec_mix, dec_sel;
  xret_act_e act;
  logic      mode_unpred, use_hyp;
  logic      exec_q;

  xret_fixed_dec #(.IW(IW)) u_fix (
    .instr (instr),
    .dec   (dec_fix)
  );

  xret_mixed_dec #(.IW(IW)) u_mix (
    .instr          (instr),
    .in_cblock      (in_cblock),
    .last_in_cblock (last_in_cblock),
    .dec            (dec_mix)
  );

  assign dec_sel = iset_mixed ? dec_mix : dec_fix;

  xret_resolve #(.UNPRED_AS_UNDEF(UNPRED_AS_UNDEF)) u_res (
    .match       (dec_sel.match),
    .cond_pass   (cond_pass),
    .halted      (halted),
    .mode        (mode),
    .el          (el),
    .act         (act),
    .mode_unpred (mode_unpred),
    .use_hyp     (use_hyp)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid      <= 1'b0;
      match          <= 1'b0;
      src_hyp        <= 1'b0;
      ret_addr       <= '0;
      do_restore     <= 1'b0;
      do_dbg_restore <= 1'b0;
      ctx_sync       <= 1'b0;
      undef_trap     <= 1'b0;
      nop            <= 1'b0;
      unpred         <= 1'b0;
      exec_q         <= 1'b0;
    end else begin
      out_valid      <= in_valid;
      match          <= in_valid && dec_sel.match;
      exec_q         <= in_valid && dec_sel.match && cond_pass;
      unpred         <= in_valid && (dec_sel.sb_bad || mode_unpred);
      do_restore     <= in_valid && (act == ACT_RESTORE);
      do_dbg_restore <= in_valid && (act == ACT_DBG);
      ctx_sync       <= in_valid && (act == ACT_DBG);
      undef_trap     <= in_valid && (act == ACT_UNDEF);
      nop            <= in_valid && (act == ACT_NOP);
      src_hyp        <= in_valid && (act == ACT_RESTORE) && use_hyp;
      if (in_valid && act == ACT_RESTORE)
        ret_addr <= use_hyp ? hyp_link : gpr_link;
      else
        ret_addr <= '0;
    end
  end

  // R13
  one_action_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && exec_q) |-> ($countones({do_restore, do_dbg_restore, undef_trap, nop}) == 1));

  // R6
  no_exec_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !exec_q |-> !(do_restore || do_dbg_restore || ctx_sync || undef_trap || nop));

  // R11
  sync_with_dbg_chk: assert property (@(posedge clk) disable iff (rst)
    ctx_sync |-> (do_dbg_restore && !do_restore));

  // R12
  latency_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  // R12
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> !(match || unpred || src_hyp || (ret_addr != '0)));

  // R7
  ret_src_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !rst && dec_sel.match && cond_pass && !halted &&
     (mode != MODE_USR) && (mode != MODE_SYS))
    |=> (do_restore && (ret_addr == ($past(el) == EL_HYP ? $past(hyp_link) : $past(gpr_link)))));
endmodule

// File: tb/xret_decode_tb.sv
module xret_decode_tb;
  localparam int XLEN = 32;
  localparam logic [XLEN-1:0] GPR = 32'h0000_1234;
  localparam logic [XLEN-1:0] HYP = 32'hCAFE_0040;
  localparam logic [4:0] USR = 5'b10000, SYS = 5'b11111, SVC = 5'b10011,
                         HYPM = 5'b11010, IRQ = 5'b10010;
  localparam logic [31:0] FIX = 32'hE160_006E, MIX = 32'hF3DE_8F00;

  // exp = {match, restore, dbg, ctx, undef, nop, unpred}
  typedef struct packed {
    logic [3:0]  req;
    logic [31:0] instr;
    logic        mix;
    logic [4:0]  mode;
    logic [1:0]  el;
    logic        halt;
    logic        cp;
    logic        icb;
    logic        lcb;
    logic [6:0]  exp;
  } vec_t;

  localparam int NV = 24;
  localparam vec_t VECS [NV] = '{
    '{4'd7,  FIX,          1'b0, SVC,  2'd1, 1'b0, 1'b1, 1'b0, 1'b0, 7'b1100000}, // R7
    '{4'd7,  FIX,          1'b0, HYPM, 2'd2, 1'b0, 1'b1, 1'b0, 1'b0, 7'b1100000}, // R7
    '{4'd8,  FIX,          1'b0, USR,  2'd0, 1'b0, 1'b1, 1'b0, 1'b0, 7'b1000101}, // R8
    '{4'd8,  FIX,          1'b0, SYS,  2'd1, 1'b0, 1'b1, 1'b0, 1'b0, 7'b1000101}, // R8
    '{4'd9,  FIX,          1'b0, USR,  2'd0, 1'b1, 1'b1, 1'b0, 1'b0, 7'b1000100}, // R9
    '{4'd10, FIX,          1'b0, SYS,  2'd1, 1'b1, 1'b1, 1'b0, 1'b0, 7'b1000101}, // R10
    '{4'd11, FIX,          1'b0, SVC,  2'd1, 1'b1, 1'b1, 1'b0, 1'b0, 7'b1011000}, // R11
    '{4'd1,  32'hF160_006E,1'b0, SVC,  2'd1, 1'b0, 1'b1, 1'b0, 1'b0, 7'b0000000}, // R1
    '{4'd6,  FIX,          1'b0, SVC,  2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 7'b1000000}, // R6
    '{4'd2,  32'hE160_016E,1'b0, SVC,  2'd1, 1'b0, 1'b1, 1'b0, 1'b0, 7'b1100001}, // R2
    '{4'd2,  32'hE160_006F,1'b0, SVC,  2'd1, 1'b0, 1'b1, 1'b0, 1'b0, 7'b1100001}, // R2
    '{4'd3,  MIX,          1'b1, SVC,  2'd1, 1'b0, 1'b1, 1'b0, 1'b0, 7'b1100000}, // R3
    '{4'd5,  MIX,          1'b1, SVC,  2'd1, 1'b0, 1'b1, 1'b1, 1'b0, 7'b1100001}, // R5
    '{4'd5,  MIX,          1'b1, SVC,  2'd1, 1'b0, 1'b1, 1'b1, 1'b1, 7'b1100000}, // R5
    '{4'd3,  32'hF3DE_8F01,1'b1, SVC,  2'd1, 1'b0, 1'b1, 1'b0, 1'b0, 7'b0000000}, // R3
    '{4'd4,  32'hF3DE_AF00,1'b1, SVC,  2'd1, 1'b0, 1'b1, 1'b0, 1'b0, 7'b1100001}, // R4
    '{4'd4,  32'hF3DE_8000,1'b1, SVC,  2'd1, 1'b0, 1'b1, 1'b0, 1'b0, 7'b1100001}, // R4
    '{4'd1,  FIX,          1'b1, SVC,  2'd1, 1'b0, 1'b1, 1'b0, 1'b0, 7'b0000000}, // R1
    '{4'd1,  MIX,          1'b0, SVC,  2'd1, 1'b0, 1'b1, 1'b0, 1'b0, 7'b0000000}, // R1
    '{4'd5,  FIX,          1'b0, SVC,  2'd1, 1'b0, 1'b1, 1'b1, 1'b0, 7'b1100000}, // R5
    '{4'd3,  32'hF3DE_CF00,1'b1, SVC,  2'd1, 1'b0, 1'b1, 1'b0, 1'b0, 7'b0000000}, // R3
    '{4'd3,  32'hF3DE_9F00,1'b1, SVC,  2'd1, 1'b0, 1'b1, 1'b0, 1'b0, 7'b0000000}, // R3
    '{4'd11, FIX,          1'b0, SVC,  2'd2, 1'b1, 1'b1, 1'b0, 1'b0, 7'b1011000}, // R11
    '{4'd7,  FIX,          1'b0, IRQ,  2'd3, 1'b0, 1'b1, 1'b0, 1'b0, 7'b1100000}  // R7
  };

  logic clk = 1'b0, rst = 1'b1, in_valid = 1'b0;
  logic [31:0] instr = '0;
  logic iset_mixed = 1'b0, halted = 1'b0, cond_pass = 1'b0, in_cblock = 1'b0, last_in_cblock = 1'b0;
  logic [4:0] mode = SVC;
  logic [1:0] el = 2'd0;
  logic out_valid, match, src_hyp, do_restore, do_dbg_restore, ctx_sync, undef_trap, nop, unpred;
  logic [XLEN-1:0] ret_addr;
  logic n_ov, n_m, n_s, n_r, n_d, n_c, n_u, n_n, n_p;
  logic [XLEN-1:0] n_addr;
  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  xret_decode #(.XLEN(XLEN), .UNPRED_AS_UNDEF(1'b1)) u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .instr(instr), .iset_mixed(iset_mixed),
    .mode(mode), .el(el), .halted(halted), .cond_pass(cond_pass), .in_cblock(in_cblock),
    .last_in_cblock(last_in_cblock), .gpr_link(GPR), .hyp_link(HYP),
    .out_valid(out_valid), .match(match), .src_hyp(src_hyp), .ret_addr(ret_addr),
    .do_restore(do_restore), .do_dbg_restore(do_dbg_restore), .ctx_sync(ctx_sync),
    .undef_trap(undef_trap), .nop(nop), .unpred(unpred));

  xret_decode #(.XLEN(XLEN), .UNPRED_AS_UNDEF(1'b0)) u_dut_nop (
    .clk(clk), .rst(rst), .in_valid(in_valid), .instr(instr), .iset_mixed(iset_mixed),
    .mode(mode), .el(el), .halted(halted), .cond_pass(cond_pass), .in_cblock(in_cblock),
    .last_in_cblock(last_in_cblock), .gpr_link(GPR), .hyp_link(HYP),
    .out_valid(n_ov), .match(n_m), .src_hyp(n_s), .ret_addr(n_addr),
    .do_restore(n_r), .do_dbg_restore(n_d), .ctx_sync(n_c),
    .undef_trap(n_u), .nop(n_n), .unpred(n_p));

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  function automatic logic [6:0] flags();
    return {match, do_restore, do_dbg_restore, ctx_sync, undef_trap, nop, unpred};
  endfunction

  task automatic drive(input vec_t v);
    instr = v.instr; iset_mixed = v.mix; mode = v.mode; el = v.el;
    halted = v.halt; cond_pass = v.cp; in_cblock = v.icb; last_in_cblock = v.lcb;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    // R12: reset clears outputs even with a strobe present
    @(negedge clk);
    drive(VECS[0]); in_valid = 1'b1;
    @(negedge clk); @(negedge clk);
    check("R12 reset", {out_valid, flags(), ret_addr}, '0);
    rst = 1'b0;
    // R12: output lags one cycle; before the edge, still zero
    check("R12 pre-edge", {out_valid, flags()}, '0);

    foreach (VECS[i]) begin
      logic [XLEN-1:0] ea;
      logic es;
      drive(VECS[i]);
      in_valid = 1'b1;
      @(negedge clk);
      ea = VECS[i].exp[5] ? (VECS[i].el == 2'd2 ? HYP : GPR) : '0;
      es = VECS[i].exp[5] && (VECS[i].el == 2'd2);
      check($sformatf("R%0d vec %0d flags", VECS[i].req, i), {out_valid, flags()}, {1'b1, VECS[i].exp});
      // R13: address and source zero unless restore
      check($sformatf("R13/R7 vec %0d addr", i), {src_hyp, ret_addr}, {es, ea});
    end

    // R12: no strobe -> quiet on the next cycle
    drive(VECS[0]); in_valid = 1'b0;
    @(negedge clk);
    check("R12 idle", {out_valid, flags(), ret_addr}, '0);

    // R8: no-op resolution instance, User mode running
    drive(VECS[2]); in_valid = 1'b1;
    @(negedge clk);
    check("R8 nop variant", {n_m, n_r, n_d, n_c, n_u, n_n, n_p}, 7'b1000011);
    // R10: no-op resolution instance, halted System
    drive(VECS[5]);
    @(negedge clk);
    check("R10 nop variant", {n_m, n_r, n_d, n_c, n_u, n_n, n_p}, 7'b1000011);
    // R9: halted User still traps on the no-op variant
    drive(VECS[4]);
    @(negedge clk);
    check("R9 nop variant", {n_m, n_r, n_d, n_c, n_u, n_n, n_p}, 7'b1000100);
    // R12: reset in mid-stream clears outputs
    rst = 1'b1;
    @(negedge clk);
    check("R12 mid reset", {out_valid, flags(), ret_addr}, '0);
    rst = 1'b0; in_valid = 1'b0;
    @(negedge clk);
    finish_run();
  end
endmodule